// File: doc/BRIEF.md
# Start/Stop Framed Serial Word Aligner

This block sits behind a clock-recovery front end. It takes a retimed serial stream, one bit per clock with a bit-valid strobe, and finds the boundary of 20-bit frames. Each frame carries an 18-bit payload between a leading start bit and a trailing stop bit. The aligner checks one candidate boundary at a time. When a candidate fails it slips by one bit and tries again. Once enough frames in a row agree, it declares lock and presents each payload on a parallel bus with a one-cycle word-valid pulse, synchronous to the word clock.

While locked, it keeps checking every frame. Frames with broken framing are withheld. A run of such frames drops lock, and the boundary search begins again. All widths and thresholds are parameters. The defaults are an 18-bit payload, 4 frames to lock and 4 errors to unlock.

Top module: `start_stop_aligner`

## Requirements
- R1: After reset, `locked` is 0, `wordValid` is 0 and `wordOut` is all zeros.
- R2: A frame is 20 bits, sent least significant bit first. Frame bit 0 is the start bit (value 1). Frame bits 1 to 18 hold the payload, payload bit 0 first. Frame bit 19 is the stop bit (value 0). A delivered word places frame bit i+1 on `wordOut[i]`.
- R3: While searching, `locked` rises at the clock edge that takes the stop bit of the 4th consecutive frame with valid framing at the same boundary. With a clean aligned stream from reset, it rises after exactly 4 frames and not after 3.
- R4: While searching, a failed check clears the run of good frames and slips the boundary by one bit, so the next check comes 21 valid bits later. A single leading junk bit of value 0 ahead of aligned frames therefore gives lock after 1 + 5x20 = 101 valid bits, and not after 81.
- R5: While locked, each frame with valid framing gives a single-cycle `wordValid` pulse in the cycle after the edge that takes its stop bit, with its payload on `wordOut`. The frame that completes lock is delivered the same way.
- R6: While locked, a frame whose start bit is 0 or whose stop bit is 1 gives no `wordValid` and leaves `wordOut` unchanged. One good frame clears the run of consecutive errors.
- R7: While locked, the 4th consecutive framing error drops `locked` at the edge that takes that frame's stop bit. The search then restarts with a one-bit slip.
- R8: While unlocked, `wordValid` stays 0 and `wordOut` holds its last value.
- R9: Cycles with `bitValid` low neither shift the stream nor advance the frame position. Idle cycles inserted between bits do not change the recovered words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered word-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Retimed serial data bit |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| wordOut | output | 18 | Recovered payload, valid on the rising edge while `wordValid` is high |
| wordValid | output | 1 | One-cycle pulse per delivered payload |
| locked | output | 1 | Frame boundary found and being tracked |

## Verification
A wrong bit position or a missed slip shows at the ports within one frame. Either lock comes later than the exact bit count predicted from the junk prefix, or the payload shows up rotated by one bit. A wrong good-run or error-run count shows as `locked` changing one frame early or one frame late against a fixed sequence of good and broken frames. A datapath that shifts on idle cycles corrupts the very next payload when gaps are inserted between bits.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  // Strobes from control to datapath, valid in the cycle of a frame check.
  typedef struct packed {
    logic slip;     // hold the position counter for one extra valid bit
    logic deliver;  // register the payload and pulse word-valid
  } alignCtrlT;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } alignStateT;
endpackage

// File: rtl/frame_align_dp.sv
module frame_align_dp
  import frame_align_pkg::*;
#(
  parameter int PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitIn,
  input  logic                 bitValid,
  input  alignCtrlT            ctrl,
  output logic                 frameDue,
  output logic                 frameOk,
  output logic [PAYLOAD_W-1:0] wordOut,
  output logic                 wordValid
);
  localparam int FRAME_W = PAYLOAD_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0]   shiftQ;
  logic [FRAME_W-1:0]   shiftD;
  logic [CNT_W-1:0]     posQ;
  logic                 holdQ;
  logic [PAYLOAD_W-1:0] wordQ;
  logic                 wordValidQ;
  logic [PAYLOAD_W-1:0] payloadD;

  // Oldest bit ends at index 0 once a full frame has entered.
  assign shiftD = {bitIn, shiftQ[FRAME_W-1:1]};

  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_payload
    assign payloadD[i] = shiftD[i+1];
  end

  assign frameDue = bitValid && !holdQ && (posQ == LAST_POS);
  assign frameOk  = shiftD[0] && !shiftD[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      posQ   <= '0;
      holdQ  <= 1'b0;
    end else if (bitValid) begin
      shiftQ <= shiftD;
      if (holdQ) begin
        holdQ <= 1'b0;
      end else if (posQ == LAST_POS) begin
        posQ  <= '0;
        holdQ <= ctrl.slip;
      end else begin
        posQ <= posQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ      <= '0;
      wordValidQ <= 1'b0;
    end else begin
      wordValidQ <= ctrl.deliver;
      if (ctrl.deliver) wordQ <= payloadD;
    end
  end

  assign wordOut   = wordQ;
  assign wordValid = wordValidQ;
endmodule

// File: rtl/frame_align_ctrl.sv
module frame_align_ctrl
  import frame_align_pkg::*;
#(
  parameter int LOCK_FRAMES = 4,
  parameter int UNLOCK_ERRS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameDue,
  input  logic      frameOk,
  output alignCtrlT ctrl,
  output logic      locked
);
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam int ERR_W  = $clog2(UNLOCK_ERRS + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
  localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(UNLOCK_ERRS - 1);

  alignStateT        stateQ;
  logic [GOOD_W-1:0] goodQ;
  logic [ERR_W-1:0]  errQ;

  always_comb begin
    ctrl = '0;
    if (frameDue) begin
      if (stateQ == ST_SEARCH) begin
        if (frameOk) ctrl.deliver = (goodQ == GOOD_LAST);
        else         ctrl.slip    = 1'b1;
      end else begin
        if (frameOk)               ctrl.deliver = 1'b1;
        else if (errQ == ERR_LAST) ctrl.slip    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_SEARCH;
      goodQ  <= '0;
      errQ   <= '0;
    end else if (frameDue) begin
      if (stateQ == ST_SEARCH) begin
        if (!frameOk) begin
          goodQ <= '0;
        end else if (goodQ == GOOD_LAST) begin
          stateQ <= ST_LOCKED;
          goodQ  <= '0;
          errQ   <= '0;
        end else begin
          goodQ <= goodQ + 1'b1;
        end
      end else begin
        if (frameOk) begin
          errQ <= '0;
        end else if (errQ == ERR_LAST) begin
          stateQ <= ST_SEARCH;
          errQ   <= '0;
          goodQ  <= '0;
        end else begin
          errQ <= errQ + 1'b1;
        end
      end
    end
  end

  assign locked = (stateQ == ST_LOCKED);
endmodule

// File: rtl/start_stop_aligner.sv
module start_stop_aligner
  import frame_align_pkg::*;
#(
  parameter int PAYLOAD_W   = 18,
  parameter int LOCK_FRAMES = 4,
  parameter int UNLOCK_ERRS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitIn,
  input  logic                 bitValid,
  output logic [PAYLOAD_W-1:0] wordOut,
  output logic                 wordValid,
  output logic                 locked
);
  alignCtrlT ctrl;
  logic      frameDue;
  logic      frameOk;

  frame_align_dp #(.PAYLOAD_W(PAYLOAD_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitIn    (bitIn),
    .bitValid (bitValid),
    .ctrl     (ctrl),
    .frameDue (frameDue),
    .frameOk  (frameOk),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  frame_align_ctrl #(
    .LOCK_FRAMES(LOCK_FRAMES),
    .UNLOCK_ERRS(UNLOCK_ERRS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameDue (frameDue),
    .frameOk  (frameOk),
    .ctrl     (ctrl),
    .locked   (locked)
  );
endmodule

// File: rtl/start_stop_aligner_chk.sv
module start_stop_aligner_chk #(
  parameter int PAYLOAD_W = 18
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bitIn,
  input logic                 bitValid,
  input logic [PAYLOAD_W-1:0] wordOut,
  input logic                 wordValid,
  input logic                 locked
);
  // R8: no word is presented without lock
  assert_valid_needs_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> locked);

  // R6 / R8: the payload bus only changes together with a word-valid pulse
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> wordValid);

  // R5: word-valid is a single-cycle pulse (a frame spans many bits)
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R3: lock is gained only on a frame that is delivered
  assert_lock_with_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> wordValid);

  // R9: a delivered word follows a cycle that carried a valid bit
  assert_word_needs_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(bitValid));

  // R7: lock is lost only on a cycle that carried a valid bit
  assert_unlock_needs_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(bitValid));
endmodule

bind start_stop_aligner start_stop_aligner_chk #(.PAYLOAD_W(PAYLOAD_W)) chk_i (.*);

// File: tb/start_stop_aligner_tb_top.sv
module start_stop_aligner_tb_top;
  localparam int PW = 18;

  typedef struct packed {
    logic [PW-1:0] payload;
    logic          startB;
    logic          stopB;
    logic          expValid;
    logic          expLocked;
  } vecT;

  // Walked while locked: good delivery, error runs, recovery, loss of lock.
  localparam int NV = 10;
  localparam vecT VECS [NV] = '{
    '{18'h2A5C3, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h1F00E, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h3FFFF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{18'h00001, 1'b0, 1'b0, 1'b0, 1'b1},
    '{18'h12345, 1'b1, 1'b1, 1'b0, 1'b1},
    '{18'h0C0C0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h33333, 1'b0, 1'b0, 1'b0, 1'b1},
    '{18'h0AAAA, 1'b1, 1'b1, 1'b0, 1'b1},
    '{18'h15555, 1'b1, 1'b1, 1'b0, 1'b1},
    '{18'h2FEDC, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitIn = 1'b0;
  logic          bitValid = 1'b0;
  logic [PW-1:0] wordOut;
  logic          wordValid;
  logic          locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [PW-1:0] expOut;

  always #2 clk = ~clk;

  start_stop_aligner dut_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .wordOut(wordOut), .wordValid(wordValid), .locked(locked)
  );

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge.
  task automatic sendBit(input logic b, input bit gap);
    if (gap) begin
      bitValid = 1'b0;
      bitIn    = ~b;
      @(negedge clk);
    end
    bitIn    = b;
    bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendFrame(input logic [PW-1:0] p, input logic s, input logic e, input bit gap);
    sendBit(s, gap);
    for (int i = 0; i < PW; i++) sendBit(p[i], gap);
    sendBit(e, gap);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    bitValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // R8: a word must never appear while unlocked
  always @(negedge clk) begin
    if (rstN && wordValid && !locked) begin
      errors++;
      $display("FAIL R8 actual=wordValid1_unlocked expected=0");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    checkVal("R1 locked", locked, 0);
    checkVal("R1 wordValid", wordValid, 0);
    checkVal("R1 wordOut", wordOut, 0);

    // R3 / R5 / R2: aligned stream, lock after exactly 4 frames
    sendFrame(18'h00011, 1'b1, 1'b0, 1'b0);
    sendFrame(18'h00022, 1'b1, 1'b0, 1'b0);
    sendFrame(18'h00033, 1'b1, 1'b0, 1'b0);
    checkVal("R3 not locked after 3", locked, 0);
    sendFrame(18'h2B4E1, 1'b1, 1'b0, 1'b0);
    checkVal("R3 locked after 4", locked, 1);
    checkVal("R5 lock frame valid", wordValid, 1);
    checkVal("R2 lock frame payload", wordOut, 18'h2B4E1);
    expOut = 18'h2B4E1;
    @(negedge clk);
    checkVal("R5 pulse one cycle", wordValid, 0);

    // Vector table: R5 delivery, R6 errors withheld, R7 loss of lock
    foreach (VECS[k]) begin
      sendFrame(VECS[k].payload, VECS[k].startB, VECS[k].stopB, 1'b0);
      if (VECS[k].expValid) expOut = VECS[k].payload;
      checkVal($sformatf("R5/R6 vec%0d valid", k), wordValid, VECS[k].expValid);
      checkVal($sformatf("R6 vec%0d wordOut", k), wordOut, expOut);
      checkVal($sformatf("R7 vec%0d locked", k), locked, VECS[k].expLocked);
    end

    // R8: unlocked, output holds under further traffic
    sendFrame(18'h3C3C3, 1'b1, 1'b0, 1'b0);
    checkVal("R8 unlocked no lock", locked, 0);
    checkVal("R8 unlocked wordOut hold", wordOut, expOut);

    // R4: one junk 0 bit then frames: fail, slip, lock after 101 bits
    doReset();
    sendBit(1'b0, 1'b0);
    sendFrame(18'h00F0F, 1'b1, 1'b0, 1'b0);
    sendFrame(18'h0F0F0, 1'b1, 1'b0, 1'b0);
    sendFrame(18'h11111, 1'b1, 1'b0, 1'b0);
    sendFrame(18'h22222, 1'b1, 1'b0, 1'b0);
    checkVal("R4 not locked after 81 bits", locked, 0);
    sendFrame(18'h35A5A, 1'b1, 1'b0, 1'b0);
    checkVal("R4 locked after 101 bits", locked, 1);
    checkVal("R4 slipped payload", wordOut, 18'h35A5A);

    // R9: idle cycles between bits do not disturb the words
    sendFrame(18'h2D2D2, 1'b1, 1'b0, 1'b1);
    checkVal("R9 gap valid", wordValid, 1);
    checkVal("R9 gap payload", wordOut, 18'h2D2D2);
    sendFrame(18'h01234, 1'b1, 1'b0, 1'b1);
    checkVal("R9 gap payload 2", wordOut, 18'h01234);

    // R4 / R2: arbitrary offset, zero-payload training, then data
    doReset();
    for (int j = 0; j < 13; j++) sendBit(((j * 5) % 3) == 1, 1'b0);
    for (int f = 0; f < 30; f++) sendFrame('0, 1'b1, 1'b0, 1'b0);
    checkVal("R4 offset search locked", locked, 1);
    sendFrame(18'h1ACE5, 1'b1, 1'b0, 1'b0);
    checkVal("R2 offset payload valid", wordValid, 1);
    checkVal("R2 offset payload", wordOut, 18'h1ACE5);
    sendFrame(18'h20001, 1'b1, 1'b0, 1'b0);
    checkVal("R2 bit order edges", wordOut, 18'h20001);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule